// File: doc/BRIEF.md
# UART Interrupt Aggregator

This block gathers every interrupt source of a serial port into one request line. Error and line events arrive as single-cycle pulses: receive timeout, framing error, parity error, break, overrun and a clear-to-send change. The receive and transmit FIFO fill counts arrive as levels. Each event sets a sticky bit in a raw status register. A mask register selects which raw bits may drive the combined interrupt output. Software acknowledges an event by writing ones to the clear port.

The raw, mask, masked and clear vectors all use the same 11-bit layout. The FIFO-level events compare each fill count against a threshold. Software picks that threshold as a fraction of the FIFO depth through a 6-bit level-select register. Receive and transmit level events are edge-triggered. Receive sets when the fill moves up to or past its threshold. Transmit sets when the fill moves down to or past its threshold.

Top module: `uart_irq_aggregator`

## Requirements
- R1: Bit layout in raw, mask, masked and clear vectors: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit level, 4 receive level, 1 clear-to-send change. Bits 3, 2 and 0 always read 0 in raw, mask and masked status, even when written as 1.
- R2: `maskedStatus` equals `rawStatus` AND `maskReg`, and `irqOut` is the OR of all `maskedStatus` bits.
- R3: A clear write sets to 0 each raw bit whose `clrWrData` bit is 1, on the next clock edge. Raw bits whose `clrWrData` bit is 0 keep their value.
- R4: If an event and a clear of the same bit happen in the same cycle, the bit ends up set.
- R5: A raw bit becomes 1 on the clock edge after its event and holds until it is cleared.
- R6: Level select bits [5:3] hold the receive code and bits [2:0] hold the transmit code. Codes 0, 1, 2, 3 and 4 select 1/8, 1/4, 1/2, 3/4 and 7/8 of `FIFO_DEPTH`. Codes 5, 6 and 7 select 1/2.
- R7: Raw bit 4 sets in the cycle `rxFill` goes from below the receive threshold to at or above it. A fill that stays at or above the threshold does not set the bit again after a clear.
- R8: Raw bit 5 sets in the cycle `txFill` goes from above the transmit threshold to at or below it. Out of reset the transmit fill counts as already at or below the threshold, so an empty transmit FIFO sets nothing.
- R9: Reset sets raw status, mask, level select and `irqOut` to 0.
- R10: A mask write loads `maskReg` from `maskWrData` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxFill | input | CNT_W | Receive FIFO fill count |
| txFill | input | CNT_W | Transmit FIFO fill count |
| evTimeout | input | 1 | Receive timeout pulse |
| evFraming | input | 1 | Framing error pulse |
| evParity | input | 1 | Parity error pulse |
| evBreak | input | 1 | Break pulse |
| evOverrun | input | 1 | Overrun pulse |
| evCtsChange | input | 1 | Clear-to-send change pulse |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 11 | Mask write value |
| clrWrEn | input | 1 | Clear write strobe |
| clrWrData | input | 11 | Write-one-to-clear value |
| lvlWrEn | input | 1 | Level select write strobe |
| lvlWrData | input | 6 | Level select write value |
| rawStatus | output | 11 | Raw status |
| maskReg | output | 11 | Mask register |
| maskedStatus | output | 11 | Masked status |
| levelSel | output | 6 | Level select register |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. The unsupported bits must stay at zero. An empty mask must keep the interrupt low. A mask write must load the mask, and a clear must drop a raw bit when no event competes with it. An event must win over a same-cycle clear, and a set bit must hold while no clear arrives. The fraction each level code selects, and the edge-only behaviour of the FIFO-level events, can only be shown by the bench scenarios. Those scenarios include a fill that sits above its threshold after a clear, a reserved code, and the quiet transmit FIFO out of reset.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W = 11;

  localparam int BIT_CTS      = 1;
  localparam int BIT_RXLVL    = 4;
  localparam int BIT_TXLVL    = 5;
  localparam int BIT_TIMEOUT  = 6;
  localparam int BIT_FRAMING  = 7;
  localparam int BIT_PARITY   = 8;
  localparam int BIT_BREAK    = 9;
  localparam int BIT_OVERRUN  = 10;

  localparam logic [IRQ_W-1:0] SUPPORTED = 11'h7F2;

  typedef struct packed {
    logic [IRQ_W-1:0] setVec;
    logic [IRQ_W-1:0] clrVec;
    logic             maskLoad;
    logic             lvlLoad;
  } irq_strobe_t;

  // Threshold in entries for a level code and a FIFO depth.
  function automatic int levelThreshold(input logic [2:0] code, input int depth);
    int eighths;
    case (code)
      3'd0:    eighths = 1;
      3'd1:    eighths = 2;
      3'd2:    eighths = 4;
      3'd3:    eighths = 6;
      3'd4:    eighths = 7;
      default: eighths = 4;
    endcase
    return (depth * eighths) / 8;
  endfunction
endpackage

// File: rtl/uart_irq_level_det.sv
module uart_irq_level_det #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter bit RISING     = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fill,
  input  logic [2:0]       code,
  output logic             crossEvt
);
  import uart_irq_pkg::*;

  logic [CNT_W-1:0] thresh;
  logic             inZone;
  logic             inZoneQ;

  assign thresh = CNT_W'(levelThreshold(code, FIFO_DEPTH));

  generate
    if (RISING) begin : g_rise
      assign inZone = (fill >= thresh);
    end else begin : g_fall
      assign inZone = (fill <= thresh);
    end
  endgenerate

  // Falling detectors start "in zone" so an empty FIFO is quiet after reset.
  always_ff @(posedge clk) begin
    if (!rstN) inZoneQ <= !RISING;
    else       inZoneQ <= inZone;
  end

  assign crossEvt = inZone & ~inZoneQ;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxFill,
  input  logic [CNT_W-1:0] txFill,
  input  logic             evTimeout,
  input  logic             evFraming,
  input  logic             evParity,
  input  logic             evBreak,
  input  logic             evOverrun,
  input  logic             evCtsChange,
  input  logic             maskWrEn,
  input  logic             clrWrEn,
  input  logic [IRQ_W-1:0] clrWrData,
  input  logic             lvlWrEn,
  input  logic [5:0]       levelSel,
  output irq_strobe_t      strobe
);
  logic rxCross;
  logic txCross;

  uart_irq_level_det #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .RISING(1'b1)) u_rxDet (
    .clk(clk), .rstN(rstN), .fill(rxFill), .code(levelSel[5:3]), .crossEvt(rxCross)
  );

  uart_irq_level_det #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .RISING(1'b0)) u_txDet (
    .clk(clk), .rstN(rstN), .fill(txFill), .code(levelSel[2:0]), .crossEvt(txCross)
  );

  always_comb begin
    strobe = '0;
    strobe.setVec[BIT_CTS]     = evCtsChange;
    strobe.setVec[BIT_RXLVL]   = rxCross;
    strobe.setVec[BIT_TXLVL]   = txCross;
    strobe.setVec[BIT_TIMEOUT] = evTimeout;
    strobe.setVec[BIT_FRAMING] = evFraming;
    strobe.setVec[BIT_PARITY]  = evParity;
    strobe.setVec[BIT_BREAK]   = evBreak;
    strobe.setVec[BIT_OVERRUN] = evOverrun;
    strobe.clrVec   = clrWrEn ? clrWrData : '0;
    strobe.maskLoad = maskWrEn;
    strobe.lvlLoad  = lvlWrEn;
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irq_strobe_t      strobe,
  input  logic [IRQ_W-1:0] maskWrData,
  input  logic [5:0]       lvlWrData,
  output logic [IRQ_W-1:0] rawStatus,
  output logic [IRQ_W-1:0] maskReg,
  output logic [IRQ_W-1:0] maskedStatus,
  output logic [5:0]       levelSel,
  output logic             irqOut
);
  logic [IRQ_W-1:0] rawQ;
  logic [IRQ_W-1:0] maskQ;
  logic [5:0]       lvlQ;

  // Set is applied after clear so a simultaneous event wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ  <= '0;
      maskQ <= '0;
      lvlQ  <= '0;
    end else begin
      rawQ <= ((rawQ & ~strobe.clrVec) | strobe.setVec) & SUPPORTED;
      if (strobe.maskLoad) maskQ <= maskWrData & SUPPORTED;
      if (strobe.lvlLoad)  lvlQ  <= lvlWrData;
    end
  end

  assign rawStatus    = rawQ;
  assign maskReg      = maskQ;
  assign maskedStatus = rawQ & maskQ;
  assign levelSel     = lvlQ;
  assign irqOut       = |maskedStatus;
endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxFill,
  input  logic [CNT_W-1:0] txFill,
  input  logic             evTimeout,
  input  logic             evFraming,
  input  logic             evParity,
  input  logic             evBreak,
  input  logic             evOverrun,
  input  logic             evCtsChange,
  input  logic             maskWrEn,
  input  logic [10:0]      maskWrData,
  input  logic             clrWrEn,
  input  logic [10:0]      clrWrData,
  input  logic             lvlWrEn,
  input  logic [5:0]       lvlWrData,
  output logic [10:0]      rawStatus,
  output logic [10:0]      maskReg,
  output logic [10:0]      maskedStatus,
  output logic [5:0]       levelSel,
  output logic             irqOut
);
  import uart_irq_pkg::*;

  irq_strobe_t strobe;

  uart_irq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxFill(rxFill), .txFill(txFill),
    .evTimeout(evTimeout), .evFraming(evFraming), .evParity(evParity),
    .evBreak(evBreak), .evOverrun(evOverrun), .evCtsChange(evCtsChange),
    .maskWrEn(maskWrEn), .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .lvlWrEn(lvlWrEn), .levelSel(levelSel), .strobe(strobe)
  );

  uart_irq_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskWrData(maskWrData),
    .lvlWrData(lvlWrData), .rawStatus(rawStatus), .maskReg(maskReg),
    .maskedStatus(maskedStatus), .levelSel(levelSel), .irqOut(irqOut)
  );
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        evFraming,
  input logic        evOverrun,
  input logic        maskWrEn,
  input logic [10:0] maskWrData,
  input logic        clrWrEn,
  input logic [10:0] clrWrData,
  input logic [10:0] rawStatus,
  input logic [10:0] maskReg,
  input logic [10:0] maskedStatus,
  input logic        irqOut
);
  AST_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus | maskReg | maskedStatus) & 11'h00D) == 11'h000); // R1

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == 11'h000) |-> !irqOut); // R2

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrEn && clrWrData[7] && !evFraming) |=> !rawStatus[7]); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evOverrun |=> rawStatus[10]); // R4

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[9] && !(clrWrEn && clrWrData[9])) |=> rawStatus[9]); // R5

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> (maskReg == ($past(maskWrData) & 11'h7F2))); // R10
endmodule

bind uart_irq_aggregator uart_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .evFraming(evFraming), .evOverrun(evOverrun),
  .maskWrEn(maskWrEn), .maskWrData(maskWrData), .clrWrEn(clrWrEn),
  .clrWrData(clrWrData), .rawStatus(rawStatus), .maskReg(maskReg),
  .maskedStatus(maskedStatus), .irqOut(irqOut)
);

// File: tb/sim_uart_irq_aggregator.sv
`timescale 1ns/1ps
module sim_uart_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NVEC = 10;

  // {events cts,overrun,break,parity,framing,timeout ; clear ; expected raw}
  localparam logic [27:0] VEC [NVEC] = '{
    {6'b000001, 11'h000, 11'h040},
    {6'b000010, 11'h000, 11'h0C0},
    {6'b001100, 11'h000, 11'h3C0},
    {6'b000000, 11'h040, 11'h380},
    {6'b010000, 11'h400, 11'h780},
    {6'b100000, 11'h00D, 11'h782},
    {6'b000000, 11'h7FF, 11'h000},
    {6'b111111, 11'h000, 11'h7C2},
    {6'b000000, 11'h182, 11'h640},
    {6'b000000, 11'h640, 11'h000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] rxFill = '0, txFill = '0;
  logic evTimeout = 0, evFraming = 0, evParity = 0, evBreak = 0, evOverrun = 0, evCtsChange = 0;
  logic maskWrEn = 0, clrWrEn = 0, lvlWrEn = 0;
  logic [10:0] maskWrData = '0, clrWrData = '0;
  logic [5:0] lvlWrData = '0;
  logic [10:0] rawStatus, maskReg, maskedStatus;
  logic [5:0] levelSel;
  logic irqOut;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_aggregator #(.FIFO_DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock edge; inputs set before this call are sampled, strobes drop afterwards.
  task automatic step();
    @(posedge clk);
    #1;
    {evTimeout, evFraming, evParity, evBreak, evOverrun, evCtsChange} = '0;
    maskWrEn = 0; clrWrEn = 0; lvlWrEn = 0;
  endtask

  task automatic writeMask(input logic [10:0] v);
    maskWrEn = 1; maskWrData = v; step();
  endtask
  task automatic writeClr(input logic [10:0] v);
    clrWrEn = 1; clrWrData = v; step();
  endtask
  task automatic writeLvl(input logic [2:0] rxCode, input logic [2:0] txCode);
    lvlWrEn = 1; lvlWrData = {rxCode, txCode}; step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1;
    step(); step(); step();
    // R9 reset state, R8 empty tx FIFO quiet after reset
    check("R9 raw", rawStatus, 0);
    check("R9 mask", maskReg, 0);
    check("R9 levelSel", levelSel, 0);
    check("R9 irq", irqOut, 0);
    check("R8 tx quiet out of reset", rawStatus[5], 0);

    // R10 and R1: mask write, unsupported bits dropped
    writeMask(11'h7FF);
    check("R10/R1 mask load", maskReg, 11'h7F2);

    // Table walk: R3 R4 R5 R1 R2
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] ev;
      ev = VEC[i][27:22];
      {evCtsChange, evOverrun, evBreak, evParity, evFraming, evTimeout} = ev;
      clrWrData = VEC[i][21:11];
      clrWrEn = (VEC[i][21:11] != 0);
      step();
      check("R3/R4/R5 raw vector", rawStatus, VEC[i][10:0]);
      check("R2 masked vector", maskedStatus, VEC[i][10:0] & 11'h7F2);
      check("R2 irq vector", irqOut, VEC[i][10:0] != 0);
    end

    // R2: masking selects which bits drive irq
    evParity = 1; step();
    writeMask(11'h100);
    check("R2 masked parity", maskedStatus, 11'h100);
    check("R2 irq on", irqOut, 1);
    writeMask(11'h080);
    check("R2 masked other", maskedStatus, 11'h000);
    check("R2 irq off", irqOut, 0);
    check("R5 parity held", rawStatus, 11'h100);
    writeClr(11'h7FF);
    writeMask(11'h7F2);

    // R7/R6: receive level, code 0 -> 2 entries
    rxFill = 1; step();
    check("R7 below threshold", rawStatus[4], 0);
    rxFill = 2; step();
    check("R7 reach 1/8", rawStatus[4], 1);
    rxFill = 3; writeClr(11'h010);
    check("R7 cleared", rawStatus[4], 0);
    step();
    check("R7 no re-set while above", rawStatus[4], 0);
    rxFill = 0; step();
    writeLvl(3'd4, 3'd0);
    check("R6 levelSel field", levelSel, 6'b100_000);
    rxFill = 13; step();
    check("R6 7/8 not reached at 13", rawStatus[4], 0);
    rxFill = 14; step();
    check("R6 7/8 reached at 14", rawStatus[4], 1);
    rxFill = 0; writeClr(11'h7FF);
    writeLvl(3'd6, 3'd0);
    rxFill = 7; step();
    check("R6 reserved code below half", rawStatus[4], 0);
    rxFill = 8; step();
    check("R6 reserved code at half", rawStatus[4], 1);
    rxFill = 0; writeClr(11'h7FF);

    // R8/R6: transmit level, code 3 -> 12 entries
    writeLvl(3'd0, 3'd3);
    txFill = 13; step();
    check("R8 above threshold", rawStatus[5], 0);
    txFill = 12; step();
    check("R8 fall to 3/4", rawStatus[5], 1);
    writeClr(11'h7FF);
    txFill = 13; step();
    writeLvl(3'd0, 3'd1);
    txFill = 5; step();
    check("R8 1/4 not reached at 5", rawStatus[5], 0);
    txFill = 4; step();
    check("R8 fall to 1/4", rawStatus[5], 1);
    check("R2 irq from tx level", irqOut, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule